// File: doc/BRIEF.md
# Time-Bin Coincidence Trigger

The block receives a stream of hit timestamps from time-to-digital converter channels and finds coincidences by histogramming. Each timestamp is scaled into a time bin whose width is a power of two, and the bin's hit counter is incremented. Sixteen counters form a circular window of consecutive bins that starts at a window base. When a hit lands beyond the top of the window, the window slides forward by one bin per cycle. The oldest bin is evaluated against a multiplicity threshold and its counter is cleared for reuse.

A bin whose final count reaches the threshold produces one trigger primitive. The primitive carries the absolute bin number and the count, and it appears exactly one cycle after the bin leaves the window. Primitives therefore come out as a single list ordered by time. Hits that fall before the window base are dropped and tallied in a saturating late-hit counter. A synchronous clear restarts the whole histogram. The threshold and the bin-width exponent are static settings that are changed only while no hit is offered.

Top module: `tbt_trigger`

## Requirements
- R1: The bin number of a hit is `hit_ts >> e`, where e is `cfg_shift`; a `cfg_shift` above 8 acts as 8, so bin widths run from 1 to 256 timestamp units.
- R2: Each accepted hit whose bin lies inside the window raises that bin's count by one. A count saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R3: The window covers bins base to base+NBINS-1 (NBINS=16). A valid hit with bin ≥ base+NBINS holds `hit_ready` low. In each such cycle, base advances by one and the bin that was at base is evicted. The hit is taken once it fits.
- R4: Evicting a bin with count c drives `prim_valid` high for one cycle in the next cycle, if and only if c ≠ 0 and c ≥ `cfg_thresh`. `prim_bin` then holds the absolute bin number and `prim_count` holds c.
- R5: Primitives are emitted in strictly increasing bin order, and each bin produces at most one primitive.
- R6: A valid hit with bin < base is accepted, touches no counter, and raises `late_count` by one, saturating at 2^LATE_W-1 (15 by default).
- R7: While `clr` is high, `hit_ready` is low and no hit is taken. In the cycle after `clr`, `late_count` is 0 and `prim_valid` is low, and the base and all counts are 0.
- R8: After reset, `prim_valid` is low, `late_count` is 0, the base is 0, all counts are 0, and `hit_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counts, base and late tally |
| cfg_shift | input | 4 | Bin-width exponent (bin width = 2^cfg_shift, clamped at 8) |
| cfg_thresh | input | CNT_W | Multiplicity threshold |
| hit_valid | input | 1 | Timestamp offered |
| hit_ts | input | TS_W | Hit timestamp |
| hit_ready | output | 1 | Timestamp accepted this cycle |
| prim_valid | output | 1 | Trigger primitive present |
| prim_bin | output | TS_W | Absolute bin number of the primitive |
| prim_count | output | CNT_W | Final count of that bin |
| late_count | output | LATE_W | Saturating count of dropped late hits |

## Verification
A bad counter slot, a bin-index mapping error or a wrong base shows up only when the affected bin is evicted. The fault then appears as a missing, extra or wrong-count primitive one cycle after eviction. The stimulus therefore forces evictions right after each hit pattern. A base that is off by one also shifts every following `prim_bin`, and it changes which hits are counted as late, so it surfaces both in the primitive list and in `late_count` within a few cycles.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
    localparam int unsigned MAX_SHIFT = 8;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_LATE = 2'd1,
        HIT_FAR  = 2'd2,
        HIT_IN   = 2'd3
    } hit_cls_e;
endpackage

// File: rtl/tbt_bin_map.sv
module tbt_bin_map #(
    parameter int unsigned TS_W  = 16,
    parameter int unsigned NBINS = 16
) (
    input  logic                     hit_valid,
    input  logic [TS_W-1:0]          hit_ts,
    input  logic [3:0]               shift,
    input  logic [TS_W-1:0]          base,
    output logic [$clog2(NBINS)-1:0] slot,
    output tbt_pkg::hit_cls_e        cls
);
    localparam int unsigned IDX_W = $clog2(NBINS);

    logic [3:0]      shift_eff;
    logic [TS_W-1:0] bin;
    logic [TS_W-1:0] offs;

    always_comb begin
        shift_eff = (shift > 4'(tbt_pkg::MAX_SHIFT)) ? 4'(tbt_pkg::MAX_SHIFT) : shift;
        bin       = hit_ts >> shift_eff;
        offs      = bin - base;
        slot      = bin[IDX_W-1:0];
        if (!hit_valid)                 cls = tbt_pkg::HIT_NONE;
        else if (bin < base)            cls = tbt_pkg::HIT_LATE;
        else if (offs >= TS_W'(NBINS))  cls = tbt_pkg::HIT_FAR;
        else                            cls = tbt_pkg::HIT_IN;
    end
endmodule

// File: rtl/tbt_counter_bank.sv
module tbt_counter_bank #(
    parameter int unsigned NBINS = 16,
    parameter int unsigned CNT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     inc_en,
    input  logic [$clog2(NBINS)-1:0] inc_idx,
    input  logic                     evict_en,
    input  logic [$clog2(NBINS)-1:0] evict_idx,
    output logic [CNT_W-1:0]         evict_cnt
);
    localparam int unsigned IDX_W   = $clog2(NBINS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d [NBINS];
    logic [CNT_W-1:0] cnt_q [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_slot
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (clr) begin
                cnt_d[g] = '0;
            end else if (evict_en && evict_idx == IDX_W'(g)) begin
                cnt_d[g] = '0;
            end else if (inc_en && inc_idx == IDX_W'(g) && cnt_q[g] != CNT_MAX) begin
                cnt_d[g] = cnt_q[g] + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d[g];
        end
    end

    assign evict_cnt = cnt_q[evict_idx];
endmodule

// File: rtl/tbt_trigger.sv
module tbt_trigger #(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned NBINS  = 16,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned LATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [3:0]        cfg_shift,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic              hit_valid,
    input  logic [TS_W-1:0]   hit_ts,
    output logic              hit_ready,
    output logic              prim_valid,
    output logic [TS_W-1:0]   prim_bin,
    output logic [CNT_W-1:0]  prim_count,
    output logic [LATE_W-1:0] late_count
);
    localparam int unsigned IDX_W = $clog2(NBINS);
    localparam logic [LATE_W-1:0] LATE_MAX = '1;

    typedef struct packed {
        logic [TS_W-1:0]   base;
        logic [LATE_W-1:0] late;
        logic              pv;
        logic [TS_W-1:0]   pbin;
        logic [CNT_W-1:0]  pcnt;
    } state_t;

    state_t st_d, st_q;

    tbt_pkg::hit_cls_e cls;
    logic [IDX_W-1:0]  hit_slot;
    logic [CNT_W-1:0]  old_cnt;
    logic              inc_en;
    logic              adv_en;

    tbt_bin_map #(.TS_W(TS_W), .NBINS(NBINS)) u_map (
        .hit_valid (hit_valid),
        .hit_ts    (hit_ts),
        .shift     (cfg_shift),
        .base      (st_q.base),
        .slot      (hit_slot),
        .cls       (cls)
    );

    assign inc_en = !clr && (cls == tbt_pkg::HIT_IN);
    assign adv_en = !clr && (cls == tbt_pkg::HIT_FAR);

    tbt_counter_bank #(.NBINS(NBINS), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .inc_en    (inc_en),
        .inc_idx   (hit_slot),
        .evict_en  (adv_en),
        .evict_idx (st_q.base[IDX_W-1:0]),
        .evict_cnt (old_cnt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        if (clr) begin
            st_d = '0;
        end else begin
            unique case (cls)
                tbt_pkg::HIT_LATE: begin
                    if (st_q.late != LATE_MAX) st_d.late = st_q.late + 1'b1;
                end
                tbt_pkg::HIT_FAR: begin
                    st_d.pv   = (old_cnt != '0) && (old_cnt >= cfg_thresh);
                    st_d.pbin = st_q.base;
                    st_d.pcnt = old_cnt;
                    st_d.base = st_q.base + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_ready  = !clr && (cls != tbt_pkg::HIT_FAR);
    assign prim_valid = st_q.pv;
    assign prim_bin   = st_q.pbin;
    assign prim_count = st_q.pcnt;
    assign late_count = st_q.late;
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned LATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic [CNT_W-1:0]  cfg_thresh,
    input logic              hit_ready,
    input logic              prim_valid,
    input logic [TS_W-1:0]   prim_bin,
    input logic [CNT_W-1:0]  prim_count,
    input logic [LATE_W-1:0] late_count
);
    logic            seen_q;
    logic [TS_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (clr) begin
            seen_q <= 1'b0;
        end else if (prim_valid) begin
            seen_q <= 1'b1;
            last_q <= prim_bin;
        end
    end

    AST_CLR_BLOCKS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !hit_ready); // R7
    AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (late_count == '0) && !prim_valid); // R7
    AST_PRIM_MEETS_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid |-> (prim_count != '0) && (prim_count >= cfg_thresh)); // R4
    AST_PRIM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_valid && seen_q && !clr) |-> (prim_bin > last_q)); // R5
    AST_LATE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> late_count >= $past(late_count)); // R6
    AST_LATE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && late_count == '1) |=> late_count == '1); // R6
endmodule

bind tbt_trigger tbt_checker #(.TS_W(TS_W), .CNT_W(CNT_W), .LATE_W(LATE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cfg_thresh (cfg_thresh),
    .hit_ready  (hit_ready),
    .prim_valid (prim_valid),
    .prim_bin   (prim_bin),
    .prim_count (prim_count),
    .late_count (late_count)
);

// File: tb/tbt_trigger_bench.sv
`timescale 1ns/1ps
module tbt_trigger_bench;
    localparam int NB = 16;
    localparam int CMAX = 15;
    localparam int LMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  cfg_shift = 4'd0;
    logic [3:0]  cfg_thresh = 4'd1;
    logic        hit_valid = 1'b0;
    logic [15:0] hit_ts = '0;
    logic        hit_ready;
    logic        prim_valid;
    logic [15:0] prim_bin;
    logic [3:0]  prim_count;
    logic [3:0]  late_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_base = 0;
    int m_late = 0;
    int m_cnt[int];
    bit m_pv = 1'b0;
    int m_pbin = 0;
    int m_pcnt = 0;

    always #5 clk = ~clk;

    tbt_trigger u_tbt_trigger (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_shift(cfg_shift),
        .cfg_thresh(cfg_thresh), .hit_valid(hit_valid), .hit_ts(hit_ts),
        .hit_ready(hit_ready), .prim_valid(prim_valid), .prim_bin(prim_bin),
        .prim_count(prim_count), .late_count(late_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_shift();
        return (cfg_shift > 4'd8) ? 8 : int'(cfg_shift);
    endfunction

    // One clock of stimulus; model advances in step with the design.
    task automatic step(input bit v, input int ts, input bit c, output bit rdy);
        int bin;
        bit late_h, far_h;
        @(negedge clk);
        hit_valid = v;
        hit_ts = 16'(ts);
        clr = c;
        #1;
        bin = ts >> eff_shift();               // R1
        late_h = v && (bin < m_base);
        far_h = v && !late_h && (bin - m_base >= NB);
        rdy = !c && !far_h;
        check(hit_ready == rdy, "R3", "hit_ready", int'(hit_ready), int'(rdy));
        m_pv = 1'b0;
        if (c) begin
            m_base = 0; m_late = 0; m_cnt.delete();
        end else if (late_h) begin
            if (m_late < LMAX) m_late++;
        end else if (far_h) begin
            int cc;
            cc = m_cnt.exists(m_base) ? m_cnt[m_base] : 0;
            m_pv = (cc != 0) && (cc >= int'(cfg_thresh));
            m_pbin = m_base;
            m_pcnt = cc;
            m_cnt.delete(m_base);
            m_base++;
        end else if (v) begin
            int cc;
            cc = m_cnt.exists(bin) ? m_cnt[bin] : 0;
            if (cc < CMAX) cc++;                 // R2
            m_cnt[bin] = cc;
        end
        @(posedge clk);
        #1;
        hit_valid = 1'b0;
        clr = 1'b0;
        check(late_count == 4'(m_late), "R6", "late_count", int'(late_count), m_late);
        check(prim_valid == m_pv, "R4", "prim_valid", int'(prim_valid), int'(m_pv));
        if (m_pv && prim_valid) begin
            check(int'(prim_bin) == m_pbin, "R5", "prim_bin", int'(prim_bin), m_pbin);
            check(int'(prim_count) == m_pcnt, "R2", "prim_count", int'(prim_count), m_pcnt);
        end
    endtask

    task automatic send(input int ts);
        bit rdy;
        for (int k = 0; k < 4000; k++) begin
            step(1'b1, ts, 1'b0, rdy);
            if (rdy) break;
        end
    endtask

    task automatic idle(input int n);
        bit rdy;
        for (int k = 0; k < n; k++) step(1'b0, 0, 1'b0, rdy);
    endtask

    task automatic do_clear();
        bit rdy;
        step(1'b0, 0, 1'b1, rdy);
        check(late_count == 4'd0, "R7", "late_count after clr", int'(late_count), 0);
        check(!prim_valid, "R7", "prim_valid after clr", int'(prim_valid), 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit rdy;
        int lcg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        check(!prim_valid, "R8", "prim_valid", int'(prim_valid), 0);
        check(late_count == 0, "R8", "late_count", int'(late_count), 0);
        check(hit_ready, "R8", "hit_ready", int'(hit_ready), 1);
        idle(2);

        // R1/R2/R4: width 4, threshold 3
        cfg_shift = 4'd2; cfg_thresh = 4'd3;
        for (int t = 0; t < 6; t++) send(t);
        send(8); send(9); send(10); send(12);
        send(64);          // bin 16, evicts bin 0
        send(80);          // evicts bins 1..4
        send(0);           // R6 late hit
        idle(1);

        // R2 saturation and R6 late saturation
        for (int k = 0; k < 20; k++) send(84);
        for (int k = 0; k < 17; k++) send(3);
        send(40 * 4);      // flush: bin 21 fires with 15
        idle(1);

        // R7: clear mid-stream, hit offered during clr is not taken
        send(41 * 4);
        step(1'b1, 41 * 4 + 1, 1'b1, rdy);
        check(!rdy && !hit_ready, "R7", "hit_ready during clr", int'(hit_ready), 0);
        do_clear();

        // R1: width 1, threshold 1
        cfg_shift = 4'd0; cfg_thresh = 4'd1;
        idle(1);
        send(3); send(3); send(5); send(7); send(15);
        send(40);
        idle(1);

        // R1: exponent 9 acts as 8
        do_clear();
        cfg_shift = 4'd9; cfg_thresh = 4'd2;
        idle(1);
        send(16'h0100); send(16'h0180); send(16'h0200); send(16'h02FF);
        send(16'h1400);
        idle(1);

        // R3/R5: long jittered stream, width 2, threshold 2
        do_clear();
        cfg_shift = 4'd1; cfg_thresh = 4'd2;
        idle(1);
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            send(i * 2 + ((lcg >> 8) % 24));
            if (((lcg >> 16) % 5) == 0) idle(1);
        end
        send(4000);
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule